// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction Processor Core

This block is a 32-bit processor core that fetches, decodes and executes one instruction in every clock cycle. The program counter, the register file and the data memory all change on the same rising edge, so each instruction's effects are visible before the next edge. Instructions and data sit in two separate internal word arrays. The instruction array is read on every cycle and has no read enable.

The core runs a reduced load/store instruction set. It has word load and store, five register-to-register operations (add, subtract, AND, OR, signed set-less-than), branch-if-equal and an absolute jump. A main decoder turns the opcode into datapath select signals: write-register choice, ALU operand choice, write-back source, register write, memory read/write, branch, jump and a two-bit ALU class. A second decoder turns the ALU class and the function field into an ALU operation. Any encoding that neither decoder knows retires as a no-op.

Both arrays are filled through a preload port, normally while reset is held. The register write port, the data-memory write port and the current program counter appear on outputs, so every architectural change can be seen from outside the core.

Top module: `sc_core`

## Requirements
- R1: While reset is low the program counter reads 0. Reset clears all 32 registers to zero, and the data memory keeps its contents through reset.
- R2: For every instruction that is neither a taken branch nor a jump, the next program counter is the current one plus 4. The instruction word is taken from the instruction array at word index pc[7:2].
- R3: An instruction with opcode bits[31:26] = 0x00 reads registers rs = bits[25:21] and rt = bits[20:16], and writes its result into rd = bits[15:11]. The function field bits[5:0] selects the operation: 0x20 adds, 0x22 subtracts (rs minus rt), 0x24 is AND, 0x25 is OR, and 0x2A writes 1 if rs < rt as signed numbers and 0 otherwise.
- R4: Opcode 0x23 (load word) writes into rt the data word at byte address rs + sign-extended bits[15:0]. The word index is that address's bits [7:2].
- R5: Opcode 0x2B (store word) writes rt's value into data memory at byte address rs + sign-extended bits[15:0]. It writes no register, and a later load from the same address returns the stored value.
- R6: Opcode 0x04 (branch-if-equal) compares rs and rt. If they are equal, the next PC is PC + 4 + (sign-extended bits[15:0] shifted left by 2). If they differ, the next PC is PC + 4. The instruction writes nothing.
- R7: Opcode 0x02 (jump) sets the next PC to {(PC+4)[31:28], bits[25:0], 2'b00} and writes nothing.
- R8: Register 0 always reads as zero. A write aimed at register 0 is dropped, and rf_we_o stays low for it.
- R9: An opcode outside {0x00, 0x23, 0x2B, 0x04, 0x02}, or an opcode 0x00 instruction whose function field is outside the five listed codes, writes neither a register nor memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_imem_we | input | 1 | Preload strobe for the instruction array |
| ld_dmem_we | input | 1 | Preload strobe for the data array (takes priority over a store) |
| ld_addr | input | LD_AW (6) | Word index for preload |
| ld_data | input | 32 | Word to preload |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word being executed |
| rf_we_o | output | 1 | Register write happens at the coming edge |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | Store happens at the coming edge |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Store data (rt value) |

## Verification
The assertions check, on every cycle, the rules that the instruction word and the PC alone decide. Sequential instructions step the PC by 4. A jump lands on the target built from the field. Register 0 never gets a write strobe. Unknown encodings and stores never write a register, and each write targets rd or rt according to the opcode class. The values that flow through the datapath can only be shown by the bench's programs. These include the ALU results of the five operations and signed comparison across the sign boundary. They also include load data, store-then-load through a negative offset, register 0 reading as zero, registers cleared by a second reset, and the taken, untaken and backward branch paths.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;
   localparam logic [5:0] OPC_BREQ  = 6'h04;
   localparam logic [5:0] OPC_JUMP  = 6'h02;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [1:0] {
      CLS_ADD  = 2'b00,
      CLS_SUB  = 2'b01,
      CLS_FUNC = 2'b10
   } alu_cls_e;

   typedef enum logic [2:0] {
      OP_ADD,
      OP_SUB,
      OP_AND,
      OP_OR,
      OP_SLT
   } alu_op_e;

   typedef struct packed {
      logic     dst_is_rd;
      logic     opb_is_imm;
      logic     wb_from_mem;
      logic     reg_write;
      logic     mem_read;
      logic     mem_write;
      logic     branch;
      logic     jump;
      alu_cls_e alu_cls;
   } ctrl_t;
endpackage

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   output ctrl_t      ctrl
);
   always_comb begin
      ctrl = '0;
      ctrl.alu_cls = CLS_ADD;
      unique case (opcode)
         OPC_RTYPE: begin
            ctrl.dst_is_rd = 1'b1;
            ctrl.reg_write = 1'b1;
            ctrl.alu_cls   = CLS_FUNC;
         end
         OPC_LOAD: begin
            ctrl.opb_is_imm  = 1'b1;
            ctrl.wb_from_mem = 1'b1;
            ctrl.reg_write   = 1'b1;
            ctrl.mem_read    = 1'b1;
         end
         OPC_STORE: begin
            ctrl.opb_is_imm = 1'b1;
            ctrl.mem_write  = 1'b1;
         end
         OPC_BREQ: begin
            ctrl.branch  = 1'b1;
            ctrl.alu_cls = CLS_SUB;
         end
         OPC_JUMP: ctrl.jump = 1'b1;
         default: ctrl = '0;
      endcase
   end
endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
   import sc_pkg::*;
(
   input  alu_cls_e   cls,
   input  logic [5:0] funct,
   output alu_op_e    op,
   output logic       op_known
);
   always_comb begin
      op       = OP_ADD;
      op_known = 1'b1;
      unique case (cls)
         CLS_ADD: op = OP_ADD;
         CLS_SUB: op = OP_SUB;
         CLS_FUNC: begin
            unique case (funct)
               FN_ADD: op = OP_ADD;
               FN_SUB: op = OP_SUB;
               FN_AND: op = OP_AND;
               FN_OR:  op = OP_OR;
               FN_SLT: op = OP_SLT;
               default: op_known = 1'b0;
            endcase
         end
         default: op_known = 1'b0;
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);
   logic [W-1:0] diff;
   logic         lt;

   assign diff = a - b;
   assign lt   = (a[W-1] != b[W-1]) ? a[W-1] : diff[W-1];

   always_comb begin
      unique case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = diff;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_SLT:  y = {{(W-1){1'b0}}, lt};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int unsigned W     = 32,
   parameter int unsigned NREGS = 32,
   parameter bit          CLEAR = 1'b1,
   localparam int unsigned AW   = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_a,
   output logic [W-1:0]  rdata_b,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata
);
   logic [W-1:0] regs [NREGS];

   if (CLEAR) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
         end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
         end
      end
   end else begin : g_noclear
      always_ff @(posedge clk) begin
         if (we && waddr != '0) regs[waddr] <= wdata;
      end
   end

   assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
   assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NREGS    = 32,
   parameter int unsigned IMEM_AW  = 6,
   parameter int unsigned DMEM_AW  = 6,
   parameter bit          RF_CLEAR = 1'b1,
   localparam int unsigned LD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW,
   localparam int unsigned RAW     = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_imem_we,
   input  logic              ld_dmem_we,
   input  logic [LD_AW-1:0]  ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   output logic [DATA_W-1:0] pc_o,
   output logic [DATA_W-1:0] instr_o,
   output logic              rf_we_o,
   output logic [RAW-1:0]    rf_waddr_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic              dm_we_o,
   output logic [DATA_W-1:0] dm_addr_o,
   output logic [DATA_W-1:0] dm_wdata_o
);
   localparam int unsigned IWORDS = 1 << IMEM_AW;
   localparam int unsigned DWORDS = 1 << DMEM_AW;

   if (DATA_W != 32) begin : g_bad_w
      $error("sc_core: instruction fields require DATA_W == 32");
   end
   if (NREGS != 32) begin : g_bad_r
      $error("sc_core: 5-bit register fields require NREGS == 32");
   end
   if (IMEM_AW < 2 || IMEM_AW > 12 || DMEM_AW < 2 || DMEM_AW > 12) begin : g_bad_a
      $error("sc_core: memory address widths must lie in 2..12");
   end

   logic [DATA_W-1:0] imem [IWORDS];
   logic [DATA_W-1:0] dmem [DWORDS];

   logic [DATA_W-1:0] pc_q, pc_next, pc_plus4, br_target, j_target;
   logic [DATA_W-1:0] instr, imm_sx, rs_val, rt_val, opb, alu_y, mem_rd, wb_val;
   logic [5:0]        opcode, funct;
   logic [RAW-1:0]    rs_a, rt_a, rd_a, dst_a;
   ctrl_t             ctrl;
   alu_op_e           alu_op;
   logic              op_known, alu_zero, take_br, rf_we, dm_we;

   // Fetch
   always_ff @(posedge clk) begin
      if (ld_imem_we) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
   end
   assign instr = imem[pc_q[IMEM_AW+1:2]];

   // Decode fields
   assign opcode = instr[31:26];
   assign rs_a   = instr[25:21];
   assign rt_a   = instr[20:16];
   assign rd_a   = instr[15:11];
   assign funct  = instr[5:0];
   assign imm_sx = {{(DATA_W-16){instr[15]}}, instr[15:0]};

   sc_main_ctrl u_mctl (
      .opcode (opcode),
      .ctrl   (ctrl)
   );

   sc_alu_ctrl u_actl (
      .cls      (ctrl.alu_cls),
      .funct    (funct),
      .op       (alu_op),
      .op_known (op_known)
   );

   assign dst_a = ctrl.dst_is_rd ? rd_a : rt_a;
   assign rf_we = ctrl.reg_write && op_known && (dst_a != '0);

   sc_regfile #(
      .W     (DATA_W),
      .NREGS (NREGS),
      .CLEAR (RF_CLEAR)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .raddr_a (rs_a),
      .raddr_b (rt_a),
      .rdata_a (rs_val),
      .rdata_b (rt_val),
      .we      (rf_we),
      .waddr   (dst_a),
      .wdata   (wb_val)
   );

   // Execute
   assign opb = ctrl.opb_is_imm ? imm_sx : rt_val;

   sc_alu #(.W(DATA_W)) u_alu (
      .a    (rs_val),
      .b    (opb),
      .op   (alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // Data memory: preload has priority over a store
   assign dm_we  = ctrl.mem_write;
   assign mem_rd = dmem[alu_y[DMEM_AW+1:2]];
   always_ff @(posedge clk) begin
      if (ld_dmem_we)  dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
      else if (dm_we)  dmem[alu_y[DMEM_AW+1:2]]   <= rt_val;
   end

   assign wb_val = ctrl.wb_from_mem ? mem_rd : alu_y;

   // Next PC
   assign pc_plus4  = pc_q + DATA_W'(4);
   assign br_target = pc_plus4 + {imm_sx[DATA_W-3:0], 2'b00};
   assign j_target  = {pc_plus4[DATA_W-1:28], instr[25:0], 2'b00};
   assign take_br   = ctrl.branch && alu_zero;
   assign pc_next   = ctrl.jump ? j_target : (take_br ? br_target : pc_plus4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_next;
   end

   assign pc_o       = pc_q;
   assign instr_o    = instr;
   assign rf_we_o    = rf_we;
   assign rf_waddr_o = dst_a;
   assign rf_wdata_o = wb_val;
   assign dm_we_o    = dm_we;
   assign dm_addr_o  = alu_y;
   assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] pc_o,
   input logic [31:0] instr_o,
   input logic        rf_we_o,
   input logic [4:0]  rf_waddr_o,
   input logic        dm_we_o
);
   logic [5:0]  opc;
   logic [31:0] seq_pc, jmp_pc;
   logic        known_op;

   assign opc      = instr_o[31:26];
   assign seq_pc   = pc_o + 32'd4;
   assign jmp_pc   = {seq_pc[31:28], instr_o[25:0], 2'b00};
   assign known_op = (opc == 6'h00) || (opc == 6'h23) || (opc == 6'h2B) ||
                     (opc == 6'h04) || (opc == 6'h02);

   // R2: sequential flow
   a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (opc != 6'h04 && opc != 6'h02) |=> pc_o == $past(seq_pc));

   // R7: jump target
   a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == 6'h02) |=> pc_o == $past(jmp_pc));

   // R8: no write strobe toward register 0
   a_r8_no_r0_write: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> rf_waddr_o != 5'd0);

   // R9: unknown opcode is silent
   a_r9_unknown_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !known_op |-> (!rf_we_o && !dm_we_o));

   // R5: store writes memory only
   a_r5_store_only: assert property (@(posedge clk) disable iff (!rst_n)
      dm_we_o |-> (!rf_we_o && opc == 6'h2B));

   // R3: register-type result goes to rd
   a_r3_dest_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we_o && opc == 6'h00) |-> rf_waddr_o == instr_o[15:11]);

   // R4: load result goes to rt
   a_r4_dest_rt: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we_o && opc == 6'h23) |-> rf_waddr_o == instr_o[20:16]);

   // R6/R7: branch and jump write nothing
   a_r6_ctl_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == 6'h04 || opc == 6'h02) |-> (!rf_we_o && !dm_we_o));
endmodule

bind sc_core sc_core_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pc_o       (pc_o),
   .instr_o    (instr_o),
   .rf_we_o    (rf_we_o),
   .rf_waddr_o (rf_waddr_o),
   .dm_we_o    (dm_we_o)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_imem_we = 1'b0, ld_dmem_we = 1'b0;
   logic [5:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
   logic        rf_we_o, dm_we_o;
   logic [4:0]  rf_waddr_o;

   always #5 clk = ~clk;

   sc_core u0 (
      .clk(clk), .rst_n(rst_n), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
      .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o),
      .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
      .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
   );

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
      return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
   endfunction
   function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   typedef struct packed {
      logic [31:0] ins;
      logic        we;
      logic [4:0]  wa;
      logic [31:0] wd;
      logic        mwe;
      logic [31:0] ma;
      logic [31:0] md;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{enc_i(35,0,1,0),   1'b1, 5'd1,  32'h11,       1'b0, 32'h0,  32'h0},
      '{enc_i(35,0,2,4),   1'b1, 5'd2,  32'hFFFFFFF0, 1'b0, 32'h0,  32'h0},
      '{enc_r(1,2,3,32),   1'b1, 5'd3,  32'h1,        1'b0, 32'h0,  32'h0},
      '{enc_r(1,2,4,34),   1'b1, 5'd4,  32'h21,       1'b0, 32'h0,  32'h0},
      '{enc_r(1,2,5,36),   1'b1, 5'd5,  32'h10,       1'b0, 32'h0,  32'h0},
      '{enc_r(1,2,6,37),   1'b1, 5'd6,  32'hFFFFFFF1, 1'b0, 32'h0,  32'h0},
      '{enc_r(2,1,7,42),   1'b1, 5'd7,  32'h1,        1'b0, 32'h0,  32'h0},
      '{enc_r(1,2,8,42),   1'b1, 5'd8,  32'h0,        1'b0, 32'h0,  32'h0},
      '{enc_i(43,5,4,-4),  1'b0, 5'd0,  32'h0,        1'b1, 32'hC,  32'h21},
      '{enc_i(35,0,9,12),  1'b1, 5'd9,  32'h21,       1'b0, 32'h0,  32'h0},
      '{enc_r(1,1,0,32),   1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
      '{enc_r(0,0,10,37),  1'b1, 5'd10, 32'h0,        1'b0, 32'h0,  32'h0},
      '{32'hFC21_0005,     1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
      '{enc_r(1,2,13,63),  1'b0, 5'd0,  32'h0,        1'b0, 32'h0,  32'h0},
      '{enc_i(43,0,6,16),  1'b0, 5'd0,  32'h0,        1'b1, 32'h10, 32'hFFFFFFF1},
      '{enc_i(43,0,7,20),  1'b0, 5'd0,  32'h0,        1'b1, 32'h14, 32'h1}
   };

   function automatic string tag_of(int i);
      case (i)
         0, 1, 9:   return "R4";
         8, 14, 15: return "R5";
         10, 11:    return "R8";
         12, 13:    return "R9";
         default:   return "R3";
      endcase
   endfunction

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(bit to_imem, int a, logic [31:0] d);
      @(negedge clk);
      ld_imem_we = to_imem;
      ld_dmem_we = !to_imem;
      ld_addr    = a[5:0];
      ld_data    = d;
   endtask

   task automatic put_end();
      @(negedge clk);
      ld_imem_we = 1'b0;
      ld_dmem_we = 1'b0;
   endtask

   initial begin
      // Program A preload, reset held
      for (int i = 0; i < 64; i++) put(1'b1, i, (i < NV) ? VEC[i].ins : 32'h0);
      put(1'b0, 0, 32'h11);
      put(1'b0, 1, 32'hFFFFFFF0);
      put(1'b0, 2, 32'h7);
      put_end();
      chk("R1 pc in reset", pc_o, 32'h0);
      @(negedge clk);
      chk("R1 pc held in reset", pc_o, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         chk({tag_of(i), " R2 pc"}, pc_o, 32'(i * 4));
         chk({tag_of(i), " reg we"}, {31'd0, rf_we_o}, {31'd0, VEC[i].we});
         if (VEC[i].we) begin
            chk({tag_of(i), " reg addr"}, {27'd0, rf_waddr_o}, {27'd0, VEC[i].wa});
            chk({tag_of(i), " reg data"}, rf_wdata_o, VEC[i].wd);
         end
         chk({tag_of(i), " mem we"}, {31'd0, dm_we_o}, {31'd0, VEC[i].mwe});
         if (VEC[i].mwe) begin
            chk({tag_of(i), " mem addr"}, dm_addr_o, VEC[i].ma);
            chk({tag_of(i), " mem data"}, dm_wdata_o, VEC[i].md);
         end
         @(negedge clk);
      end

      // Program B: branches, jump, register clear by reset
      rst_n = 1'b0;
      for (int i = 0; i < 12; i++) begin
         logic [31:0] w;
         case (i)
            0:       w = enc_r(6,7,12,37);
            1, 2:    w = enc_i(35,0,i,0);
            3:       w = enc_i(4,1,2,2);
            5:       w = {6'h02, 26'd11};
            6:       w = enc_i(4,1,0,5);
            7:       w = enc_i(4,0,0,-3);
            11:      w = enc_r(1,2,11,32);
            default: w = enc_r(1,1,20,32);
         endcase
         put(1'b1, i, w);
      end
      put_end();
      chk("R1 pc after second reset", pc_o, 32'h0);
      rst_n = 1'b1;
      // step 0: r6|r7 read zero after reset
      chk("R1 cleared regs pc", pc_o, 32'h0);
      chk("R1 cleared regs data", rf_wdata_o, 32'h0);
      chk("R1 cleared regs addr", {27'd0, rf_waddr_o}, 32'd12);
      @(negedge clk);
      chk("R4 dmem kept across reset", rf_wdata_o, 32'h11);
      @(negedge clk);
      @(negedge clk);
      chk("R6 at branch pc", pc_o, 32'hC);
      chk("R6 branch no write", {31'd0, rf_we_o | dm_we_o}, 32'd0);
      @(negedge clk);
      chk("R6 taken forward", pc_o, 32'h18);
      @(negedge clk);
      chk("R6 not taken", pc_o, 32'h1C);
      @(negedge clk);
      chk("R6 taken backward", pc_o, 32'h14);
      @(negedge clk);
      chk("R7 jump target", pc_o, 32'h2C);
      chk("R3 add after jump", rf_wdata_o, 32'h22);
      chk("R3 add dest", {27'd0, rf_waddr_o}, 32'd11);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule